// File: doc/BRIEF.md
# Sklansky Prefix Adder

A purely combinational binary adder of parameterised power-of-two width. Each bit position first forms a generate flag (both operand bits high) and a propagate flag (operand bits differ). A divide-and-conquer prefix network then merges these pairs. At level k, every position whose index has bit k set absorbs the group ending at the last position of the preceding 2^k-aligned block. After log2(W) levels, every carry is known at once. Each sum bit is the propagate flag of its position XORed with the carry entering that position.

The carry-in acts as the generate of a virtual position just below bit 0. It is folded into the bit-0 generate before the network, so the group generate at position i is the carry out of position i.

Merges that still need the group propagate later use full (black) cells. Merges whose group already reaches bit 0 use generate-only (grey) cells. Positions with nothing to merge at a level pass through. A typical use is the final carry-propagate addition after a partial-product reduction tree.

Top module: `skl_adder`

## Requirements
- R1: {cout_o, sum_o} equals a_i + b_i + cin_i, computed as a W+1-bit unsigned value, for any operands.
- R2: When every bit of a_i XOR b_i is 1 (full propagate), cout_o equals cin_i and every bit of sum_o equals NOT cin_i.
- R3: When bit W-1 of both a_i and b_i is 1, cout_o is 1 regardless of the lower bits and cin_i.
- R4: When bit W-1 of both a_i and b_i is 0, cout_o is 0 regardless of the lower bits and cin_i.
- R5: a_i all ones, b_i zero and cin_i 1 wraps sum_o to zero with cout_o 1.
- R6: With both operands zero, sum_o equals cin_i in bit 0 and zero elsewhere, and cout_o is 0.
- R7: The block holds no state: outputs follow the inputs within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | W | Sum bits |
| cout_o | output | 1 | Carry out of bit W-1 |

## Verification
A carry created at bit 0 by the carry-in can meet a carry created high in the word by a generating operand pair. Both then meet a long propagate run that has to carry one of them through the full depth of the prefix tree. The bench provokes this in three ways: operand pairs with b = ~a, for the full propagate run; random operands with a forced generate or kill at the top bit; and all-ones plus carry-in. For each vector, the outputs are judged against a wide reference addition and against the expected carry-out for the forced top-bit case. Every check is made a fraction of a nanosecond after the inputs change, with no clock edge in between.

// File: rtl/skl_pkg.sv
package skl_pkg;

  typedef enum logic [1:0] {
    CELL_PASS  = 2'd0,
    CELL_GREY  = 2'd1,
    CELL_BLACK = 2'd2
  } cell_kind_e;

  // Group generate from a high and a low (G,P) pair.
  function automatic logic merge_g(input logic g_hi, input logic p_hi, input logic g_lo);
    return g_hi | (p_hi & g_lo);
  endfunction

  // Group propagate from a high and a low pair.
  function automatic logic merge_p(input logic p_hi, input logic p_lo);
    return p_hi & p_lo;
  endfunction

  // Partner index at a prefix level: last bit of the preceding aligned block.
  function automatic int partner_idx(input int idx, input int lvl);
    return ((idx >> (lvl + 1)) << (lvl + 1)) + (1 << lvl) - 1;
  endfunction

  // Kind of node at (idx, lvl).
  function automatic cell_kind_e kind_of(input int idx, input int lvl);
    if (((idx >> lvl) & 1) == 0) return CELL_PASS;
    if (idx < (1 << (lvl + 1))) return CELL_GREY;
    return CELL_BLACK;
  endfunction

endpackage

// File: rtl/skl_cell.sv
module skl_cell
  import skl_pkg::*;
#(
  parameter cell_kind_e KIND = CELL_PASS
) (
  input  logic g_hi,
  input  logic p_hi,
  input  logic g_lo,
  input  logic p_lo,
  output logic g_out,
  output logic p_out
);

  generate
    if (KIND == CELL_BLACK) begin : g_black
      assign g_out = merge_g(g_hi, p_hi, g_lo);
      assign p_out = merge_p(p_hi, p_lo);
    end else if (KIND == CELL_GREY) begin : g_grey
      logic unused_p;
      assign unused_p = p_lo;
      assign g_out = merge_g(g_hi, p_hi, g_lo);
      assign p_out = 1'b0;
    end else begin : g_pass
      logic [1:0] unused_lo;
      assign unused_lo = {g_lo, p_lo};
      assign g_out = g_hi;
      assign p_out = p_hi;
    end
  endgenerate

endmodule

// File: rtl/skl_pg_gen.sv
module skl_pg_gen #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] g_o,
  output logic [W-1:0] p_o
);

  logic [W-1:0] g_raw;

  always_comb begin
    g_raw = a_i & b_i;
    p_o   = a_i ^ b_i;
    g_o   = g_raw;
    // Fold the carry-in as the generate of the virtual position below bit 0.
    g_o[0] = g_raw[0] | (p_o[0] & cin_i);
  end

endmodule

// File: rtl/skl_prefix_net.sv
module skl_prefix_net
  import skl_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  output logic [W-1:0] gg_o
);

  localparam int LEVELS = $clog2(W);

  logic [W-1:0] g_lv [0:LEVELS];
  logic [W-1:0] p_lv [0:LEVELS];

  assign g_lv[0] = g_i;
  assign p_lv[0] = p_i;

  generate
    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
      for (genvar ix = 0; ix < W; ix++) begin : g_node
        localparam cell_kind_e KND = kind_of(ix, lv);
        localparam int         LO  = (KND == CELL_PASS) ? ix : partner_idx(ix, lv);
        skl_cell #(.KIND(KND)) u_cell (
          .g_hi (g_lv[lv][ix]),
          .p_hi (p_lv[lv][ix]),
          .g_lo (g_lv[lv][LO]),
          .p_lo (p_lv[lv][LO]),
          .g_out(g_lv[lv+1][ix]),
          .p_out(p_lv[lv+1][ix])
        );
      end
    end
  endgenerate

  logic [W-1:0] unused_p_top;
  assign unused_p_top = p_lv[LEVELS];
  assign gg_o = g_lv[LEVELS];

endmodule

// File: rtl/skl_adder.sv
module skl_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  localparam int LEVELS = $clog2(W);

  generate
    if ((1 << LEVELS) != W || W < 2) begin : g_bad_width
      $error("skl_adder: W must be a power of two of at least 2");
    end
  endgenerate

  logic [W-1:0] g_bit;
  logic [W-1:0] p_bit;
  logic [W-1:0] grp_g;
  logic [W:0]   carry;

  skl_pg_gen #(.W(W)) u_pg (
    .a_i  (a_i),
    .b_i  (b_i),
    .cin_i(cin_i),
    .g_o  (g_bit),
    .p_o  (p_bit)
  );

  skl_prefix_net #(.W(W)) u_net (
    .g_i (g_bit),
    .p_i (p_bit),
    .gg_o(grp_g)
  );

  // carry[i] enters bit i; carry[W] leaves the word.
  assign carry  = {grp_g, cin_i};
  assign sum_o  = p_bit ^ carry[W-1:0];
  assign cout_o = carry[W];

endmodule

// File: rtl/skl_adder_chk.sv
module skl_adder_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         cin_i,
  input logic [W-1:0] sum_o,
  input logic         cout_o
);

  logic [W:0] ref_sum;
  logic       known;

  always_comb begin
    ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    known   = !$isunknown({a_i, b_i, cin_i, sum_o, cout_o});
  end

  always_comb begin
    if (known) begin
      a_r1_sum_matches: assert ({cout_o, sum_o} == ref_sum)
        else $error("R1 sum mismatch");
      if ((a_i ^ b_i) == {W{1'b1}}) begin
        a_r2_full_propagate: assert (cout_o == cin_i && sum_o == {W{~cin_i}})
          else $error("R2 propagate run");
      end
      if (a_i[W-1] && b_i[W-1]) begin
        a_r3_top_generate: assert (cout_o)
          else $error("R3 top generate");
      end
      if (!a_i[W-1] && !b_i[W-1]) begin
        a_r4_top_kill: assert (!cout_o)
          else $error("R4 top kill");
      end
      if (a_i == '0 && b_i == '0) begin
        a_r6_zero_operands: assert (sum_o == {{(W-1){1'b0}}, cin_i} && !cout_o)
          else $error("R6 zero operands");
      end
    end
  end

endmodule

bind skl_adder skl_adder_chk #(.W(W)) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .cin_i (cin_i),
  .sum_o (sum_o),
  .cout_o(cout_o)
);

// File: tb/skl_adder_tb.sv
module skl_adder_tb;

  localparam int W = 16;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_i;
  logic [W-1:0] b_i;
  logic         cin_i;
  logic [W-1:0] sum_o;
  logic         cout_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  skl_adder #(.W(W)) u_dut (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (cin_i),
    .sum_o (sum_o),
    .cout_o(cout_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h cin=%b)", req, act, exp, a_i, b_i, cin_i);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    @(negedge clk);
    a_i = x; b_i = y; cin_i = c;
    #1;
    check("R1", {cout_o, sum_o}, ref_add(x, y, c));
  endtask

  initial begin
    rst_n = 1'b0;
    a_i = '0; b_i = '0; cin_i = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R6 reset", {cout_o, sum_o}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R5: all ones plus carry-in wraps.
    apply({W{1'b1}}, '0, 1'b1);
    check("R5", {cout_o, sum_o}, {1'b1, {W{1'b0}}});
    apply({W{1'b1}}, {{(W-1){1'b0}}, 1'b1}, 1'b0);
    check("R5", {cout_o, sum_o}, {1'b1, {W{1'b0}}});

    // R6: zero operands.
    for (int c = 0; c < 2; c++) begin
      apply('0, '0, c[0]);
      check("R6", {cout_o, sum_o}, {{W{1'b0}}, c[0]});
    end

    // Alternating patterns.
    apply({(W/2){2'b10}}, {(W/2){2'b01}}, 1'b1);
    apply({(W/2){2'b10}}, {(W/2){2'b10}}, 1'b0);
    apply({(W/2){2'b01}}, {(W/2){2'b01}}, 1'b1);

    // R7: change inputs mid-cycle, no clock edge before sampling.
    @(posedge clk);
    #0.8;
    a_i = 16'h7fff; b_i = 16'h0001; cin_i = 1'b0;
    #0.5;
    check("R7", {cout_o, sum_o}, 17'h08000);
    a_i = 16'hffff; b_i = 16'hffff; cin_i = 1'b1;
    #0.5;
    check("R7", {cout_o, sum_o}, 17'h1ffff);

    // R2: full propagate runs.
    for (int k = 0; k < 200; k++) begin
      logic [W-1:0] x;
      logic         c;
      x = W'($urandom);
      c = 1'($urandom);
      apply(x, ~x, c);
      check("R2", {cout_o, sum_o}, {c, {W{~c}}});
    end

    // R3 / R4: forced top-bit generate or kill.
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] x, y;
      logic         c, gen;
      x = W'($urandom); y = W'($urandom);
      c = 1'($urandom); gen = 1'($urandom);
      x[W-1] = gen; y[W-1] = gen;
      apply(x, y, c);
      check(gen ? "R3" : "R4", {{W{1'b0}}, cout_o}, {{W{1'b0}}, gen});
    end

    // R1: general random operands.
    for (int k = 0; k < 3000; k++) begin
      apply(W'($urandom), W'($urandom), 1'($urandom));
    end

    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule